// File: doc/BRIEF.md
# Serial EEPROM Read Target

This block is a two-wire bus target that answers the read traffic of a byte-wide serial EEPROM. It runs on a fast system clock and oversamples the bus clock and data lines. It drives the data line only through an open-drain enable, where a 1 pulls the wire low. The storage is a register array written as inferable block RAM. Before any bus traffic, a preload port fills that array.

A master reads in one of two ways. In a current-address read it sends only a read control byte and receives the byte at the target's internal pointer. In a random read it first runs a write-type transfer that carries only the address. It then issues a repeated Start and a read control byte. The address is taken when the target acknowledges the last address byte, so a Stop in place of the repeated Start also leaves the pointer loaded. Each returned byte advances the pointer by one, and the pointer wraps at the top of the array. A parameter picks the address format: one address byte for arrays of up to 256 entries, and two address bytes above that.

Top module: `eeprom_read_target`

## Requirements
- R1: After reset, SDA is released (sda_oe = 0) and the internal pointer is 0, so the first current-address read returns the byte at address 0.
- R2: A control byte is acknowledged only when bits 7..4 equal 1010 and bits 3..1 equal chip_sel; bit 0 = 1 selects read and bit 0 = 0 selects write. On a mismatch, the ninth clock finds SDA released, and the pointer is unchanged.
- R3: After acknowledging a read control byte, the target shifts out 8 data bits, MSB first, one per SCL period.
- R4: A current-address read returns the byte at the pointer and then leaves the pointer one higher.
- R5: With ADDR_W <= 8, a write control byte followed by one acknowledged address byte loads the pointer. The load holds whether a repeated Start or a Stop follows.
- R6: With ADDR_W > 8, the high-order address byte and then the low-order address byte are each acknowledged. The pointer takes the low ADDR_W bits of the 16-bit value {high, low}.
- R7: The pointer wraps from 2^ADDR_W - 1 to 0.
- R8: In the acknowledge slot after a data byte, the target leaves SDA released whatever the master does.
- R9: sda_oe changes only while the synchronized SCL is low, except for the release on a Start or Stop.
- R10: A Stop returns the target to idle with SDA released. A Start at any point restarts control-byte reception, and the partial bits before it have no effect.
- R11: A preload write (ld_en = 1) stores ld_data at ld_addr, and later reads of that address return it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| chip_sel | input | 3 | Chip-select value matched against control bits 3..1 |
| ld_en | input | 1 | Preload write strobe |
| ld_addr | input | ADDR_W | Preload address |
| ld_data | input | 8 | Preload data |
| sda_oe | output | 1 | Open-drain enable: 1 pulls SDA low |

## Verification
The bench uses two targets with different chip selects on one shared bus: a one-byte-address target and a two-byte-address target. The read function runs in five patterns. A current read straight after reset shows whether the pointer starts at zero. A random read shows whether an address loads on a repeated Start, and an address-only write closed by a Stop shows whether it loads without one. A read at the top address followed by a current read separates wrapping from overflow. Wrong device codes, wrong chip selects and a Start cut into a half-sent control byte must all leave the pointer untouched. A high-byte value with bits above the array width shows whether the two-byte target truncates the address correctly.

// File: rtl/eeprom_rd_pkg.sv
package eeprom_rd_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_CTRL_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } tgt_state_t;
endpackage

// File: rtl/eeprom_line_cond.sv
module eeprom_line_cond #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // data edges only count as framing while SCL is high on both samples
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeprom_array.sv
module eeprom_array #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/eeprom_rd_ctrl.sv
module eeprom_rd_ctrl
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_s,
  input  logic [2:0]        chip_sel,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [ADDR_W-1:0] ptr,
  output logic              sda_oe,
  output tgt_state_t        state,
  output logic              addr_load
);
  localparam int ADDR_BYTES = (ADDR_W > BYTE_W) ? 2 : 1;
  localparam tgt_state_t FIRST_ADDR_ST = (ADDR_BYTES == 2) ? ST_AHI : ST_ALO;

  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [BYTE_W-1:0] hi_byte;
  logic              is_read;
  logic              got_byte;
  logic              ctrl_match;
  logic [ADDR_W-1:0] new_addr;

  assign got_byte   = (bit_cnt == 4'd8);
  assign ctrl_match = (shreg[7:4] == DEV_CODE) && (shreg[3:1] == chip_sel);
  assign new_addr   = ADDR_W'({hi_byte, shreg});

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      hi_byte   <= '0;
      is_read   <= 1'b0;
      ptr       <= '0;
      sda_oe    <= 1'b0;
      addr_load <= 1'b0;
    end else begin
      addr_load <= 1'b0;
      if (start_det) begin
        state   <= ST_CTRL;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_CTRL, ST_AHI, ST_ALO: begin
            if (scl_rise && !got_byte) begin
              shreg   <= {shreg[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && got_byte) begin
              bit_cnt <= '0;
              if (state == ST_CTRL) begin
                if (ctrl_match) begin
                  is_read <= shreg[0];
                  sda_oe  <= 1'b1;
                  state   <= ST_CTRL_ACK;
                end else begin
                  state <= ST_WAIT;
                end
              end else if (state == ST_AHI) begin
                hi_byte <= shreg;
                sda_oe  <= 1'b1;
                state   <= ST_AHI_ACK;
              end else begin
                ptr       <= new_addr;
                addr_load <= 1'b1;
                sda_oe    <= 1'b1;
                state     <= ST_ALO_ACK;
              end
            end
          end
          ST_CTRL_ACK: begin
            if (scl_fall) begin
              if (is_read) begin
                shreg   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                ptr     <= ptr + ADDR_W'(1);
                bit_cnt <= 4'd1;
                state   <= ST_TX;
              end else begin
                sda_oe <= 1'b0;
                state  <= FIRST_ADDR_ST;
              end
            end
          end
          ST_AHI_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_ALO;
            end
          end
          ST_ALO_ACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              state  <= ST_WAIT;
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (got_byte) begin
                sda_oe <= 1'b0;
                state  <= ST_TX_ACK;
              end else begin
                sda_oe  <= ~shreg[BYTE_W-2];
                shreg   <= {shreg[BYTE_W-2:0], 1'b0};
                bit_cnt <= bit_cnt + 4'd1;
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) state <= ST_WAIT;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/eeprom_read_target.sv
module eeprom_read_target
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        chip_sel,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [BYTE_W-1:0] ld_data,
  output logic              sda_oe
);
  logic              scl_s;
  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              start_det;
  logic              stop_det;
  logic [ADDR_W-1:0] ptr;
  logic [BYTE_W-1:0] rd_data;
  tgt_state_t        state;
  logic              addr_load;

  eeprom_line_cond #(.STAGES(SYNC_STAGES)) u_line (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_s     (scl_s),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  eeprom_array #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_array (
    .clk     (clk),
    .wr_en   (ld_en),
    .wr_addr (ld_addr),
    .wr_data (ld_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

  eeprom_rd_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_s     (sda_s),
    .chip_sel  (chip_sel),
    .rd_data   (rd_data),
    .ptr       (ptr),
    .sda_oe    (sda_oe),
    .state     (state),
    .addr_load (addr_load)
  );
endmodule

// File: rtl/eeprom_read_target_chk.sv
module eeprom_read_target_chk
  import eeprom_rd_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_s,
  input logic              start_det,
  input logic              stop_det,
  input tgt_state_t        state,
  input logic [ADDR_W-1:0] ptr,
  input logic              addr_load
);
  assert_reset_release_R1: assert property (@(posedge clk)
    rst |=> !sda_oe);

  assert_oe_rise_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  assert_oe_fall_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
    ($fell(sda_oe) && !$past(start_det || stop_det)) |-> !scl_s);

  assert_stop_release_R10: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_oe);

  assert_ackslot_release_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TX_ACK) |-> !sda_oe);

  assert_ptr_step_R4: assert property (@(posedge clk) disable iff (rst)
    $changed(ptr) |-> (addr_load || ptr == ADDR_W'($past(ptr) + 1'b1)));
endmodule

bind eeprom_read_target eeprom_read_target_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .scl_s     (scl_s),
  .start_det (start_det),
  .stop_det  (stop_det),
  .state     (state),
  .ptr       (ptr),
  .addr_load (addr_load)
);

// File: tb/test_eeprom_read_target.sv
module test_eeprom_read_target;
  localparam int Q = 8;
  localparam logic [2:0] CS_N = 3'b010;
  localparam logic [2:0] CS_W = 3'b101;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic oe_n, oe_w;
  logic sda_bus;
  assign sda_bus = sda_m & ~oe_n & ~oe_w;

  logic       ld_en_n = 1'b0, ld_en_w = 1'b0;
  logic [8:0] ld_addr = '0;
  logic [7:0] ld_data = '0;

  eeprom_read_target #(.ADDR_W(8)) i_eeprom_read_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .chip_sel(CS_N),
    .ld_en(ld_en_n), .ld_addr(ld_addr[7:0]), .ld_data(ld_data), .sda_oe(oe_n));

  eeprom_read_target #(.ADDR_W(9)) i_eeprom_read_target_wide (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .chip_sel(CS_W),
    .ld_en(ld_en_w), .ld_addr(ld_addr), .ld_data(ld_data), .sda_oe(oe_w));

  int checks = 0;
  int fails  = 0;
  logic [7:0] mem_n [256];
  logic [7:0] mem_w [512];
  int ptr_n = 0;
  int ptr_w = 0;
  logic [7:0] exp_q[$];
  logic [7:0] obs_q[$];
  string      tag_q[$];

  function automatic logic [7:0] pat(int a);
    return 8'(a * 29 + (a >> 3) + 7);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic clk_bit(input bit b, output bit r);
    sda_m = b;    qwait();
    scl_m = 1'b1; qwait();
    r = sda_bus;  qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    bit r;
    for (int i = 7; i >= 0; i--) clk_bit(v[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(output logic [7:0] v, output bit slot);
    bit r;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      clk_bit(1'b1, r);
      v = {v[6:0], r};
    end
    clk_bit(1'b1, slot); // master leaves the byte unacknowledged
  endtask

  // current-address read with the scoreboard expectation pushed first
  task automatic read_cur(input bit wide, input string req);
    bit ack, slot;
    logic [7:0] v;
    if (wide) begin
      exp_q.push_back(mem_w[ptr_w]); ptr_w = (ptr_w + 1) % 512;
    end else begin
      exp_q.push_back(mem_n[ptr_n]); ptr_n = (ptr_n + 1) % 256;
    end
    tag_q.push_back(req);
    bus_start();
    send_byte({4'b1010, wide ? CS_W : CS_N, 1'b1}, ack);
    chk(ack, "R2 read control ack", ack, 1);
    recv_byte(v, slot);
    chk(slot == 1'b1, "R8 ack slot released", slot, 1);
    bus_stop();
    chk(!oe_n && !oe_w, "R10 released after stop", {oe_w, oe_n}, 0);
    obs_q.push_back(v);
  endtask

  task automatic set_addr(input bit wide, input logic [15:0] a, input bit end_stop, input string req);
    bit ack;
    bus_start();
    send_byte({4'b1010, wide ? CS_W : CS_N, 1'b0}, ack);
    chk(ack, {req, " write control ack"}, ack, 1);
    if (wide) begin
      send_byte(a[15:8], ack);
      chk(ack, "R6 high address ack", ack, 1);
      ptr_w = a % 512;
    end else begin
      ptr_n = a % 256;
    end
    send_byte(a[7:0], ack);
    chk(ack, {req, " address ack"}, ack, 1);
    if (end_stop) bus_stop();
  endtask

  task automatic preload(input bit wide, input int a, input logic [7:0] d);
    @(negedge clk);
    ld_addr = 9'(a); ld_data = d;
    if (wide) begin ld_en_w = 1'b1; mem_w[a] = d; end
    else begin ld_en_n = 1'b1; mem_n[a] = d; end
    @(negedge clk);
    ld_en_n = 1'b0; ld_en_w = 1'b0;
  endtask

  // monitor: compares returned bytes against the expected queue
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0) begin
        logic [7:0] o;
        o = obs_q.pop_front();
        if (exp_q.size() == 0) chk(1'b0, "scoreboard underflow", o, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(o == e, t, o, e);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
  end

  initial begin
    bit ack, r;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!oe_n && !oe_w, "R1 reset release", {oe_w, oe_n}, 0);
    for (int a = 0; a < 256; a++) preload(1'b0, a, pat(a));
    for (int a = 0; a < 512; a++) preload(1'b1, a, pat(a) ^ 8'h5A);

    read_cur(1'b0, "R1 first current read at 0");
    read_cur(1'b0, "R4 current read advances");
    set_addr(1'b0, 16'h0010, 1'b0, "R5");
    read_cur(1'b0, "R3 R5 random read data MSB first");
    read_cur(1'b0, "R4 after random read");
    set_addr(1'b0, 16'h00FF, 1'b0, "R5");
    read_cur(1'b0, "R7 top address");
    read_cur(1'b0, "R7 wrap to zero");
    set_addr(1'b0, 16'h0080, 1'b1, "R5");
    read_cur(1'b0, "R5 load on stop");

    // mismatches: bad chip select and bad device code
    bus_start();
    send_byte({4'b1010, 3'b111, 1'b1}, ack);
    chk(!ack, "R2 chip select mismatch nack", ack, 0);
    bus_stop();
    bus_start();
    send_byte({4'b1011, CS_N, 1'b1}, ack);
    chk(!ack, "R2 device code mismatch nack", ack, 0);
    bus_stop();
    read_cur(1'b0, "R2 pointer untouched by mismatch");

    // start cut into a half-sent control byte
    bus_start();
    clk_bit(1'b1, r); clk_bit(1'b0, r); clk_bit(1'b1, r);
    read_cur(1'b0, "R10 restart after partial byte");

    preload(1'b0, 8'h33, 8'hC3);
    set_addr(1'b0, 16'h0033, 1'b0, "R5");
    read_cur(1'b0, "R11 preload visible");

    // two-byte address target
    set_addr(1'b1, 16'h01A5, 1'b0, "R6");
    read_cur(1'b1, "R6 wide random read");
    read_cur(1'b1, "R6 wide current read");
    set_addr(1'b1, 16'hFE42, 1'b0, "R6");
    read_cur(1'b1, "R6 wide address truncated");
    set_addr(1'b1, 16'h01FF, 1'b0, "R6");
    read_cur(1'b1, "R7 wide top");
    read_cur(1'b1, "R7 wide wrap");
    read_cur(1'b0, "R4 narrow pointer kept across other target");

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule